// File: doc/BRIEF.md
# Guarded Control and Status Register

This block holds an 8-bit control and status byte that sits beside two digital-potentiometer wiper registers. A host writes and reads bytes over a simple strobe interface; every write strobe is answered one cycle later by an acknowledge or a no-acknowledge pulse, and every read strobe by an acknowledge with the data on `host_rdata`. Writes pass through a two-stage guard. A volatile write-enable latch must be set first. A second, self-clearing latch must then be armed before the persistent bits can be changed, and it disarms itself after one such update.

Three bits are persistent: two power-on marker bits and a wiper lock bit. They are held in flops that ignore the warm reset `rst`. On the power-on input `por` they reload from `nv_image`, which is supplied by an external storage model. An update of the persistent bits, or a nonvolatile wiper write, holds the block busy for `BUSY_CYCLES` cycles. When a register update finishes, a one-cycle commit pulse carries the new persistent bits out to that storage. The lock bit and the `wp_pin` input each gate the wiper writes. The resulting permission is also driven on two output pins.

Top module: `gcsr_top`

## Requirements
- R1: A register read returns bit 7 = power-on marker high, bit 6 = `v2_stat`, bit 5 = `v1_stat`, bit 4 = 0, bit 3 = wiper lock, bit 2 = arm latch, bit 1 = write-enable latch, bit 0 = power-on marker low. Bit 4 always reads 0.
- R2: After `por`, both latches are 0, both wipers are 0, the block is not busy, and the persistent bits equal `nv_image` ({marker high, lock, marker low} from bit 2 down to bit 0).
- R3: `rst` without `por` clears both latches, both wipers and the busy state, and leaves the persistent bits unchanged.
- R4: While the arm latch is 0, the byte 0x02 sets the write-enable latch and is acknowledged, and the byte 0x00 clears it and is acknowledged. Neither byte starts a busy period.
- R5: While the write-enable latch is 0, every write is refused with a no-acknowledge and changes nothing, except a register write of 0x02.
- R6: The byte 0x06 arms the second latch only while the write-enable latch is 1 and the arm latch is 0. In that state, any register byte other than 0x00, 0x02 and 0x06 is refused.
- R7: While armed, a register byte with bit 2 set is acknowledged and does all of the following: loads marker high from bit 7, lock from bit 3 and marker low from bit 0; loads the write-enable latch from bit 1; clears the arm latch. Bits 6, 5 and 4 of that byte are ignored. While armed, 0x00 clears both latches and 0x02 changes nothing.
- R8: An accepted persistent-bit update or nonvolatile wiper write raises `nv_busy` for exactly `BUSY_CYCLES` cycles, starting the cycle after the strobe. Every write during that time is refused. Reads are still acknowledged.
- R9: `nv_commit` pulses for one cycle, in the cycle `nv_busy` falls, only after a register update. `nv_commit_bits` then holds the written persistent bits in `nv_image` order. `rst` or `por` during the busy period cancels the pulse.
- R10: A volatile wiper write (`host_nv` = 0) is accepted only when the write-enable latch is 1, the lock is 0 and the block is not busy. A nonvolatile wiper write also needs `wp_pin` = 0. `wiper_vol_ok` and `wiper_nv_ok` show these two conditions.
- R11: Wiper A (target 1) has `TAPS_A` positions, and a written value above `TAPS_A`-1 is clamped to `TAPS_A`-1. Its readback has bit 7 = 0. Wiper B (target 2) stores and reads back all 8 bits.
- R12: Acknowledge and no-acknowledge appear one cycle after the strobe and never together. A write and a read in the same cycle are handled as a write. A write to target 3 is refused. A read of target 3 returns 0 and is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous warm reset, active high |
| por | input | 1 | Synchronous power-on reset, active high |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_sel | input | 2 | Target: 0 register, 1 wiper A, 2 wiper B, 3 none |
| host_nv | input | 1 | Wiper write is nonvolatile |
| host_wdata | input | 8 | Write byte |
| host_ack | output | 1 | Acknowledge, one cycle after strobe |
| host_nak | output | 1 | No-acknowledge for a refused write |
| host_rdata | output | 8 | Read byte, updated on each read |
| v1_stat | input | 1 | Status input shown at bit 5 |
| v2_stat | input | 1 | Status input shown at bit 6 |
| wp_pin | input | 1 | Write-protect for nonvolatile wiper writes |
| nv_image | input | 3 | Stored persistent bits loaded on `por` |
| wiper_vol_ok | output | 1 | Volatile wiper write permitted |
| wiper_nv_ok | output | 1 | Nonvolatile wiper write permitted |
| wiper_a_pos | output | clog2(TAPS_A) | Wiper A position |
| wiper_b_pos | output | clog2(TAPS_B) | Wiper B position |
| nv_busy | output | 1 | Persistent write in progress |
| nv_commit | output | 1 | Persistent-bit commit pulse |
| nv_commit_bits | output | 3 | Persistent bits to store |

## Verification
A latch left in the wrong state changes the next acknowledge: a write that should be refused is acknowledged, or the other way round. It also changes `wiper_vol_ok` in the very cycle after the faulty write, so both latches are compared with a reference model on every cycle rather than only at reads. A wrong busy count or a lost commit shows up at the `nv_busy` and `nv_commit` pins exactly `BUSY_CYCLES` cycles after the update. A commit that was never made appears only after the next `por`, as stale persistent bits in the register read.

// File: rtl/gcsr_pkg.sv
package gcsr_pkg;

    // Bit positions inside the register byte (host-visible layout)
    localparam int POS_POR0 = 0;
    localparam int POS_WEL  = 1;
    localparam int POS_ARM  = 2;
    localparam int POS_LOCK = 3;
    localparam int POS_RSVD = 4;
    localparam int POS_V1   = 5;
    localparam int POS_V2   = 6;
    localparam int POS_POR1 = 7;

    localparam logic [7:0] CMD_WEL_ON  = 8'h02;
    localparam logic [7:0] CMD_WEL_OFF = 8'h00;
    localparam logic [7:0] CMD_ARM     = 8'h06;

    typedef enum logic [1:0] {
        TGT_CSR  = 2'd0,
        TGT_WPA  = 2'd1,
        TGT_WPB  = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    typedef struct packed {
        logic por1;
        logic lock;
        logic por0;
    } nvbits_t;

    typedef struct packed {
        logic wel;
        logic arm;
    } latch_t;

    typedef enum logic [2:0] {
        DEC_NAK,
        DEC_WEL_SET,
        DEC_WEL_CLR,
        DEC_ARM_SET,
        DEC_HOLD,
        DEC_NV_UPD
    } csr_dec_e;

    function automatic csr_dec_e decode_csr(latch_t l, logic [7:0] d);
        csr_dec_e r;
        r = DEC_NAK;
        if (!l.wel) begin
            if (d == CMD_WEL_ON) r = DEC_WEL_SET;
        end else if (l.arm && d[POS_ARM]) begin
            r = DEC_NV_UPD;
        end else if (d == CMD_WEL_OFF) begin
            r = DEC_WEL_CLR;
        end else if (d == CMD_WEL_ON) begin
            r = DEC_HOLD;
        end else if (d == CMD_ARM && !l.arm) begin
            r = DEC_ARM_SET;
        end
        return r;
    endfunction

    function automatic nvbits_t nv_from_byte(logic [7:0] d);
        nvbits_t n;
        n.por1 = d[POS_POR1];
        n.lock = d[POS_LOCK];
        n.por0 = d[POS_POR0];
        return n;
    endfunction

    function automatic logic [7:0] pack_csr(nvbits_t n, latch_t l, logic v1, logic v2);
        logic [7:0] r;
        r           = '0;
        r[POS_POR1] = n.por1;
        r[POS_V2]   = v2;
        r[POS_V1]   = v1;
        r[POS_RSVD] = 1'b0;
        r[POS_LOCK] = n.lock;
        r[POS_ARM]  = l.arm;
        r[POS_WEL]  = l.wel;
        r[POS_POR0] = n.por0;
        return r;
    endfunction

    function automatic logic [7:0] clamp_pos(logic [7:0] d, int taps);
        if (int'(d) > taps - 1) return 8'(taps - 1);
        return d;
    endfunction

endpackage

// File: rtl/gcsr_guard.sv
module gcsr_guard
    import gcsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  logic       csr_wr,
    input  logic [7:0] wdata,
    input  nvbits_t    nv_image,
    output latch_t     latch_q,
    output nvbits_t    nv_q,
    output logic       csr_ok,
    output logic       nv_start
);

    csr_dec_e dec;

    always_comb begin
        dec      = decode_csr(latch_q, wdata);
        csr_ok   = csr_wr && (dec != DEC_NAK);
        nv_start = csr_wr && (dec == DEC_NV_UPD);
    end

    always_ff @(posedge clk) begin
        if (por) begin
            latch_q <= '0;
            nv_q    <= nv_image;
        end else if (rst) begin
            latch_q <= '0;
        end else if (csr_wr) begin
            case (dec)
                DEC_WEL_SET: latch_q.wel <= 1'b1;
                DEC_WEL_CLR: latch_q     <= '0;
                DEC_ARM_SET: latch_q.arm <= 1'b1;
                DEC_NV_UPD: begin
                    nv_q        <= nv_from_byte(wdata);
                    latch_q.wel <= wdata[POS_WEL];
                    latch_q.arm <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R6: the arm latch is never held without the write-enable latch
    p_arm_needs_wel_r6: assert property (@(posedge clk) disable iff (rst || por)
        latch_q.arm |-> latch_q.wel);

    // R7: an accepted persistent update leaves the arm latch cleared
    p_arm_selfclear_r7: assert property (@(posedge clk) disable iff (rst || por)
        nv_start |=> !latch_q.arm);

    // R5: with the write-enable latch low, only 0x02 can change state
    p_locked_no_change_r5: assert property (@(posedge clk) disable iff (rst || por)
        (csr_wr && !latch_q.wel && wdata != CMD_WEL_ON)
        |=> (latch_q == $past(latch_q)) && (nv_q == $past(nv_q)));

endmodule

// File: rtl/gcsr_nvtimer.sv
module gcsr_nvtimer
    import gcsr_pkg::*;
#(
    parameter int BUSY_CYCLES = 20,
    localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    por,
    input  logic    start,
    input  logic    start_csr,
    input  nvbits_t bits_in,
    output logic    busy,
    output logic    commit,
    output nvbits_t commit_bits
);

    logic [CW-1:0] cnt_q;
    logic          pend_q;
    logic [CW:0]   run_q;

    assign busy = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst || por) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            commit <= 1'b0;
        end else begin
            commit <= pend_q && (cnt_q == CW'(1));
            if (start) begin
                cnt_q       <= CW'(BUSY_CYCLES);
                pend_q      <= start_csr;
                commit_bits <= bits_in;
            end else if (busy) begin
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) pend_q <= 1'b0;
            end
        end
    end

    // Run-length monitor for the busy window
    always_ff @(posedge clk) begin
        if (rst || por)  run_q <= '0;
        else if (busy)   run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    // R8: busy never lasts longer than BUSY_CYCLES
    p_busy_len_r8: assert property (@(posedge clk) disable iff (rst || por)
        busy |-> (run_q < (CW+1)'(BUSY_CYCLES)));

    // R8: a new persistent write only starts from idle
    p_start_idle_r8: assert property (@(posedge clk) disable iff (rst || por)
        start |-> !busy);

    // R9: the commit pulse coincides with the end of a busy period
    p_commit_at_fall_r9: assert property (@(posedge clk) disable iff (rst || por)
        commit |-> (!busy && $past(busy)));

endmodule

// File: rtl/gcsr_wipers.sv
module gcsr_wipers
    import gcsr_pkg::*;
#(
    parameter int TAPS_A = 100,
    parameter int TAPS_B = 256,
    localparam int NW = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                por,
    input  logic [NW-1:0]       we,
    input  logic [7:0]          wdata,
    output logic [NW-1:0][7:0]  pos
);

    for (genvar g = 0; g < NW; g++) begin : g_wiper
        localparam int TAPS = (g == 0) ? TAPS_A : TAPS_B;
        logic [7:0] pos_r;

        always_ff @(posedge clk) begin
            if (rst || por)  pos_r <= '0;
            else if (we[g])  pos_r <= clamp_pos(wdata, TAPS);
        end

        assign pos[g] = pos_r;

        // R11: a wiper position never leaves its tap range
        p_pos_in_range_r11: assert property (@(posedge clk) disable iff (rst || por)
            int'(pos_r) <= TAPS - 1);
    end

endmodule

// File: rtl/gcsr_top.sv
module gcsr_top
    import gcsr_pkg::*;
#(
    parameter int BUSY_CYCLES = 20,
    parameter int TAPS_A = 100,
    parameter int TAPS_B = 256,
    localparam int WA = $clog2(TAPS_A),
    localparam int WB = $clog2(TAPS_B)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          por,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [1:0]    host_sel,
    input  logic          host_nv,
    input  logic [7:0]    host_wdata,
    output logic          host_ack,
    output logic          host_nak,
    output logic [7:0]    host_rdata,
    input  logic          v1_stat,
    input  logic          v2_stat,
    input  logic          wp_pin,
    input  logic [2:0]    nv_image,
    output logic          wiper_vol_ok,
    output logic          wiper_nv_ok,
    output logic [WA-1:0] wiper_a_pos,
    output logic [WB-1:0] wiper_b_pos,
    output logic          nv_busy,
    output logic          nv_commit,
    output logic [2:0]    nv_commit_bits
);

    tgt_e            tgt;
    latch_t          latch_q;
    nvbits_t         nv_q;
    nvbits_t         cbits;
    logic            csr_wr;
    logic            csr_ok;
    logic            csr_nv_start;
    logic [1:0]      wiper_we;
    logic            start;
    logic            write_ok;
    logic [1:0][7:0] pos;
    logic [7:0]      rd_mux;

    assign tgt    = tgt_e'(host_sel);
    assign csr_wr = host_wr && (tgt == TGT_CSR) && !nv_busy;

    gcsr_guard u_guard (
        .clk      (clk),
        .rst      (rst),
        .por      (por),
        .csr_wr   (csr_wr),
        .wdata    (host_wdata),
        .nv_image (nvbits_t'(nv_image)),
        .latch_q  (latch_q),
        .nv_q     (nv_q),
        .csr_ok   (csr_ok),
        .nv_start (csr_nv_start)
    );

    // Wiper write permission
    always_comb begin
        wiper_vol_ok = latch_q.wel && !nv_q.lock && !nv_busy;
        wiper_nv_ok  = wiper_vol_ok && !wp_pin;
        wiper_we[0]  = host_wr && (tgt == TGT_WPA) && (host_nv ? wiper_nv_ok : wiper_vol_ok);
        wiper_we[1]  = host_wr && (tgt == TGT_WPB) && (host_nv ? wiper_nv_ok : wiper_vol_ok);
        start        = csr_nv_start || ((|wiper_we) && host_nv);
        write_ok     = csr_ok || (|wiper_we);
    end

    gcsr_nvtimer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .por         (por),
        .start       (start),
        .start_csr   (csr_nv_start),
        .bits_in     (nv_from_byte(host_wdata)),
        .busy        (nv_busy),
        .commit      (nv_commit),
        .commit_bits (cbits)
    );

    assign nv_commit_bits = cbits;

    gcsr_wipers #(.TAPS_A(TAPS_A), .TAPS_B(TAPS_B)) u_wipers (
        .clk   (clk),
        .rst   (rst),
        .por   (por),
        .we    (wiper_we),
        .wdata (host_wdata),
        .pos   (pos)
    );

    assign wiper_a_pos = pos[0][WA-1:0];
    assign wiper_b_pos = pos[1][WB-1:0];

    always_comb begin
        case (tgt)
            TGT_CSR: rd_mux = pack_csr(nv_q, latch_q, v1_stat, v2_stat);
            TGT_WPA: rd_mux = pos[0];
            TGT_WPB: rd_mux = pos[1];
            default: rd_mux = '0;
        endcase
    end

    // Host response, one cycle after the strobe
    always_ff @(posedge clk) begin
        if (rst || por) begin
            host_ack   <= 1'b0;
            host_nak   <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ack <= host_wr ? write_ok : host_rd;
            host_nak <= host_wr && !write_ok;
            if (host_rd && !host_wr) host_rdata <= rd_mux;
        end
    end

    // R8: any write while busy is refused
    p_busy_nak_r8: assert property (@(posedge clk) disable iff (rst || por)
        (host_wr && nv_busy) |=> host_nak);

    // R10: a set lock freezes both wiper positions
    p_lock_freeze_r10: assert property (@(posedge clk) disable iff (rst || por)
        nv_q.lock |=> ($stable(wiper_a_pos) && $stable(wiper_b_pos)));

    // R12: acknowledge and no-acknowledge are exclusive
    p_ack_excl_r12: assert property (@(posedge clk) disable iff (rst || por)
        !(host_ack && host_nak));

    // R1: the reserved bit of a register read is always 0
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst || por)
        (host_rd && !host_wr && tgt == TGT_CSR) |=> !host_rdata[POS_RSVD]);

endmodule

// File: tb/sim_gcsr_top.sv
module sim_gcsr_top;

    localparam int BC = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b0, por = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, host_nv = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic       v1_stat = 1'b0, v2_stat = 1'b0, wp_pin = 1'b0;
    logic [2:0] store = 3'b101;
    logic       host_ack, host_nak, wiper_vol_ok, wiper_nv_ok, nv_busy, nv_commit;
    logic [7:0] host_rdata;
    logic [6:0] wiper_a_pos;
    logic [7:0] wiper_b_pos;
    logic [2:0] nv_commit_bits;

    always #10 clk = ~clk;

    gcsr_top #(.BUSY_CYCLES(BC)) u0 (
        .clk(clk), .rst(rst), .por(por), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_nv(host_nv), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_nak(host_nak), .host_rdata(host_rdata),
        .v1_stat(v1_stat), .v2_stat(v2_stat), .wp_pin(wp_pin), .nv_image(store),
        .wiper_vol_ok(wiper_vol_ok), .wiper_nv_ok(wiper_nv_ok),
        .wiper_a_pos(wiper_a_pos), .wiper_b_pos(wiper_b_pos),
        .nv_busy(nv_busy), .nv_commit(nv_commit), .nv_commit_bits(nv_commit_bits)
    );

    int    checks = 0, failures = 0;
    bit    done = 0;
    string cur_tag = "";

    // Reference model state
    logic m_wel = 0, m_arm = 0, m_por1 = 0, m_lock = 0, m_por0 = 0, m_pend = 0;
    int   m_cnt = 0, m_wa = 0, m_wb = 0;
    logic [2:0] m_bits = 0;
    logic e_ack, e_nak, e_commit, e_read;
    logic [7:0] e_rd;
    logic [2:0] e_cbits;

    function automatic string tg(string dflt);
        return (cur_tag == "") ? dflt : cur_tag;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_csr();
        return {m_por1, v2_stat, v1_stat, 1'b0, m_lock, m_arm, m_wel, m_por0};
    endfunction

    task automatic model_step(input logic wr, rd, input logic [1:0] sel,
                              input logic nv, input logic [7:0] d, input logic p, r);
        logic busy, ok, st, scsr, vok;
        busy = (m_cnt != 0);
        e_read = 0; e_commit = 0; ok = 0; st = 0; scsr = 0;
        if (p || r) begin
            m_wel = 0; m_arm = 0; m_cnt = 0; m_pend = 0; m_wa = 0; m_wb = 0;
            e_ack = 0; e_nak = 0; e_rd = 0;
            if (p) {m_por1, m_lock, m_por0} = store;
        end else begin
            e_commit = m_pend && (m_cnt == 1);
            e_cbits  = m_bits;
            if (wr) begin
                vok = m_wel && !m_lock && !busy;
                if (sel == 2'd0 && !busy) begin
                    if (!m_wel) begin
                        if (d == 8'h02) begin m_wel = 1; ok = 1; end
                    end else if (m_arm && d[2]) begin
                        m_por1 = d[7]; m_lock = d[3]; m_por0 = d[0];
                        m_wel = d[1]; m_arm = 0; ok = 1; st = 1; scsr = 1;
                    end else if (d == 8'h00) begin
                        m_wel = 0; m_arm = 0; ok = 1;
                    end else if (d == 8'h02) begin
                        ok = 1;
                    end else if (d == 8'h06 && !m_arm) begin
                        m_arm = 1; ok = 1;
                    end
                end else if (sel == 2'd1 || sel == 2'd2) begin
                    if (nv ? (vok && !wp_pin) : vok) begin
                        ok = 1; st = nv;
                        if (sel == 2'd1) m_wa = (d > 99) ? 99 : int'(d);
                        else             m_wb = int'(d);
                    end
                end
                e_ack = ok; e_nak = !ok;
            end else if (rd) begin
                e_ack = 1; e_nak = 0; e_read = 1;
                case (sel)
                    2'd0: e_rd = exp_csr();
                    2'd1: e_rd = 8'(m_wa);
                    2'd2: e_rd = 8'(m_wb);
                    default: e_rd = 8'h00;
                endcase
            end else begin
                e_ack = 0; e_nak = 0;
            end
            if (st) begin
                m_cnt = BC; m_pend = scsr;
                if (scsr) m_bits = {d[7], d[3], d[0]};
            end else if (m_cnt != 0) begin
                if (m_cnt == 1) m_pend = 0;
                m_cnt--;
            end
            if (e_commit) store = e_cbits;
        end
    endtask

    task automatic cyc(input logic wr, rd, input logic [1:0] sel, input logic nv,
                       input logic [7:0] d, input logic p, input logic r);
        logic ev;
        host_wr = wr; host_rd = rd; host_sel = sel; host_nv = nv; host_wdata = d;
        por = p; rst = r;
        model_step(wr, rd, sel, nv, d, p, r);
        @(posedge clk);
        @(negedge clk);
        chk(tg("R12"), "ack", int'(host_ack), int'(e_ack));
        chk(tg("R12"), "nak", int'(host_nak), int'(e_nak));
        if (e_read) chk(tg("R1"), "rdata", int'(host_rdata), int'(e_rd));
        chk(tg("R8"), "busy", int'(nv_busy), int'(m_cnt != 0));
        chk(tg("R9"), "commit", int'(nv_commit), int'(e_commit && !(p || r)));
        if (e_commit && !(p || r)) chk("R9", "commit_bits", int'(nv_commit_bits), int'(e_cbits));
        ev = m_wel && !m_lock && (m_cnt == 0);
        chk(tg("R10"), "vol_ok", int'(wiper_vol_ok), int'(ev));
        chk(tg("R10"), "nv_ok", int'(wiper_nv_ok), int'(ev && !wp_pin));
        chk(tg("R11"), "pos_a", int'(wiper_a_pos), m_wa);
        chk(tg("R11"), "pos_b", int'(wiper_b_pos), m_wb);
        host_wr = 0; host_rd = 0; por = 0; rst = 0;
    endtask

    task automatic wcsr(input logic [7:0] d); cyc(1, 0, 2'd0, 0, d, 0, 0); endtask
    task automatic rd(input logic [1:0] s);   cyc(0, 1, s, 0, 8'h00, 0, 0); endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 2'd0, 0, 8'h00, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        cur_tag = "R2";
        cyc(0, 0, 2'd0, 0, 8'h00, 1, 0);
        v1_stat = 1; v2_stat = 0;
        rd(2'd0);                              // expect 0xA1
        chk("R2", "por read", int'(host_rdata), 8'hA1);

        cur_tag = "R5";
        cyc(1, 0, 2'd1, 0, 8'd5, 0, 0);        // wiper write refused
        wcsr(8'h06);
        rd(2'd0);

        cur_tag = "R4";
        wcsr(8'h02); rd(2'd0);
        wcsr(8'h00); rd(2'd0);
        wcsr(8'h02);

        cur_tag = "R6";
        wcsr(8'h08);                           // refused, not armed
        wcsr(8'h06); rd(2'd0);

        cur_tag = "R7";
        wcsr(8'hFC); rd(2'd0);                 // lock=1, wel=0, bits 6..4 ignored

        cur_tag = "R8";
        wcsr(8'h02);
        cyc(1, 0, 2'd2, 0, 8'h11, 0, 0);
        rd(2'd0);
        idle(BC);

        cur_tag = "R3";
        cyc(0, 0, 2'd0, 0, 8'h00, 0, 1);
        rd(2'd0);

        cur_tag = "R10";
        wcsr(8'h02);
        cyc(1, 0, 2'd1, 0, 8'd7, 0, 0);        // locked
        wcsr(8'h06); wcsr(8'h06);              // unlock, wel stays 1
        idle(BC + 1);
        wp_pin = 1;
        cyc(1, 0, 2'd2, 1, 8'h40, 0, 0);       // blocked by pin
        cyc(1, 0, 2'd2, 0, 8'hFF, 0, 0);       // volatile allowed
        wp_pin = 0;
        cyc(1, 0, 2'd2, 1, 8'h80, 0, 0);
        idle(BC + 1);

        cur_tag = "R11";
        cyc(1, 0, 2'd1, 0, 8'd200, 0, 0);
        rd(2'd1);
        chk("R11", "clamp readback", int'(host_rdata), 99);
        cyc(1, 0, 2'd2, 0, 8'hFF, 0, 0);
        rd(2'd2);

        cur_tag = "R9";
        wcsr(8'h06); wcsr(8'h8F);
        idle(3);
        cyc(0, 0, 2'd0, 0, 8'h00, 1, 0);       // power-on cancels commit
        rd(2'd0);
        wcsr(8'h02); wcsr(8'h06); wcsr(8'h8F);
        idle(BC + 1);
        cyc(0, 0, 2'd0, 0, 8'h00, 1, 0);
        rd(2'd0);

        cur_tag = "R12";
        wcsr(8'h02);
        cyc(1, 1, 2'd0, 0, 8'h00, 0, 0);       // write wins
        cyc(1, 0, 2'd3, 0, 8'h55, 0, 0);
        rd(2'd3);

        cur_tag = "";
        for (int i = 0; i < 3000; i++) begin
            int unsigned k;
            logic [7:0] d;
            k = $urandom % 100;
            v1_stat = 1'($urandom); v2_stat = 1'($urandom);
            wp_pin  = (($urandom % 4) == 0);
            case ($urandom % 5)
                0: d = 8'h00;
                1: d = 8'h02;
                2: d = 8'h06;
                3: d = 8'($urandom) | 8'h04;
                default: d = 8'($urandom);
            endcase
            if (k < 1)       cyc(0, 0, 2'd0, 0, 8'h00, 1, 0);
            else if (k < 2)  cyc(0, 0, 2'd0, 0, 8'h00, 0, 1);
            else if (k < 50) wcsr(d);
            else if (k < 70) cyc(1, 0, 2'(1 + ($urandom % 2)), 1'($urandom), 8'($urandom), 0, 0);
            else if (k < 95) rd(2'($urandom));
            else             idle(1);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule